// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a pipelined static RAM with its own burst address generator. Each word is 18 bits wide and split into two 9-bit byte lanes. The depth is set by a parameter. A burst starts when either of two address strobes loads a base address. The CPU strobe always starts a read. The controller strobe starts a read or a write, chosen by the lane write enables. After that first beat, an advance input either steps the burst through four interleaved beats or holds the address to insert a wait state.

The chip enable is sampled only when a base address is loaded, and that value governs the whole burst. Writes go into the array on the clock edge of their cycle. Read data is registered and comes out one clock after the cycle that addressed it.

Read data leaves the block on a valid-only stream with no back-pressure: the consumer must take each word in the cycle its valid flag is high. The output enable masks the valid flag asynchronously and never changes internal state.

Top module: `bsram_core`

## Requirements
- R1: After reset no burst is active and the captured chip enable is inactive. `rvalid_o` is 0, and cycles with no strobe produce no read and no write until a base address is loaded.
- R2: A cycle with `cpu_strobe_n_i` low loads `addr_i` as the base and clears the beat counter. It performs a read at that address, whatever `ctl_strobe_n_i` and `lane_we_n_i` are, and the memory is not written.
- R3: A cycle with `ctl_strobe_n_i` low and `cpu_strobe_n_i` high loads `addr_i` as the base and clears the beat counter. It writes `wdata_i` at that address if any bit of `lane_we_n_i` is 0, and reads otherwise. A write cycle produces no valid output.
- R4: `ce_n_i` is sampled only on a base-load cycle. If it was high (inactive) at the load, every read and write of that burst is suppressed, and later values of `ce_n_i` have no effect until the next load.
- R5: On a cycle with no strobe, `adv_n_i` high keeps the burst address. The cycle then re-reads or writes the same word as a wait state.
- R6: On a cycle with no strobe, `adv_n_i` low steps a 2-bit beat counter before the access. The low two address bits equal base[1:0] XOR count, which gives the order base, base^1, base^2, base^3.
- R7: After the fourth beat the next advance returns to the base address. The address bits above bit 1 never change during a burst.
- R8: Two-cycle write: a CPU-strobe load is followed by a cycle with both strobes high and lane enables low. That second cycle writes `wdata_i` at the loaded address.
- R9: `lane_we_n_i[0]`=0 writes bits 8:0 and `lane_we_n_i[1]`=0 writes bits 17:9. A lane whose enable is high keeps its old contents.
- R10: Read data and `rvalid_o` appear after the second rising edge following the addressing cycle: one edge to register the access and one for the data-out register.
- R11: `rvalid_o` is the registered valid flag ANDed with `oe_n_i` low, and it responds without a clock edge. `oe_n_i` changes neither `rdata_o` nor any internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address |
| cpu_strobe_n_i | input | 1 | CPU address strobe, active low, forces a read |
| ctl_strobe_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce_n_i | input | 1 | Chip enable, active low, sampled at base load |
| lane_we_n_i | input | 2 | Byte-lane write enables, active low |
| wdata_i | input | 18 | Write data |
| oe_n_i | input | 1 | Output enable, active low, gates `rvalid_o` |
| rdata_o | output | 18 | Registered read data |
| rvalid_o | output | 1 | Read data valid (no ready; cannot be stalled) |

## Verification
The bench builds the core with DEPTH=64, which gives six address bits. With that setting, bases such as 0x10, 0x12, 0x13 and 0x21 keep their upper bits apart while the XOR sequence only moves the low two bits. This brings the four-beat wrap, the offset-start orders, the wait states and both lane-write paths within reach of short readback bursts. The suppressed-enable burst writes to an address that is read back afterwards, which shows at the ports that nothing was written.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsram_burst_ctrl.sv
module bsram_burst_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              cpu_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  output logic [AW-1:0]     acc_addr_o,
  output op_e               acc_op_o,
  output logic [LANES-1:0]  wr_lane_o
);
  logic [AW-1:0]     base_q, nxt_base;
  logic [BEAT_W-1:0] cnt_q, nxt_cnt;
  logic              ce_q, eff_ce;
  logic              load, cpu_load, any_we;

  assign cpu_load = !cpu_strobe_n_i;
  assign load     = cpu_load || !ctl_strobe_n_i;

  always_comb begin
    if (load) begin
      nxt_base = addr_i;
      nxt_cnt  = '0;
      eff_ce   = !ce_n_i;
      any_we   = cpu_load ? 1'b0 : |(~lane_we_n_i);
    end else begin
      nxt_base = base_q;
      nxt_cnt  = adv_n_i ? cnt_q : cnt_q + 2'd1;
      eff_ce   = ce_q;
      any_we   = |(~lane_we_n_i);
    end
  end

  assign acc_addr_o = {nxt_base[AW-1:BEAT_W], nxt_base[BEAT_W-1:0] ^ nxt_cnt};

  always_comb begin
    if (!eff_ce)     acc_op_o = OP_IDLE;
    else if (any_we) acc_op_o = OP_WRITE;
    else             acc_op_o = OP_READ;
  end

  assign wr_lane_o = (acc_op_o == OP_WRITE) ? ~lane_we_n_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ce_q   <= 1'b0;
    end else begin
      base_q <= nxt_base;
      cnt_q  <= nxt_cnt;
      ce_q   <= eff_ce;
    end
  end

  // R2
  cpu_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_strobe_n_i |-> (acc_op_o != OP_WRITE) && (wr_lane_o == '0));

  // R7
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n_i && ctl_strobe_n_i) |=>
      base_q[AW-1:BEAT_W] == $past(base_q[AW-1:BEAT_W]));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n_i && ctl_strobe_n_i && adv_n_i) |=> $stable(cnt_q));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n_i && ctl_strobe_n_i && !adv_n_i) |=> cnt_q == $past(cnt_q) + 2'd1);

  // R4
  ce_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n_i && ctl_strobe_n_i) |=> ce_q == $past(ce_q));
endmodule

// File: rtl/bsram_array.sv
module bsram_array
  import bsram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DEPTH = 1024
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_lane_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_lane_i[g]) lane_mem[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en_i) lane_q <= lane_mem[rd_addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              cpu_strobe_n_i,
  input  logic              ctl_strobe_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic [1:0]        lane_we_n_i,
  input  logic [17:0]       wdata_i,
  input  logic              oe_n_i,
  output logic [17:0]       rdata_o,
  output logic              rvalid_o
);
  logic [AW-1:0]    acc_addr;
  op_e              acc_op;
  logic [LANES-1:0] wr_lane;
  logic             rd_en_q, valid_q;
  logic [AW-1:0]    rd_addr_q;

  bsram_burst_ctrl #(.AW(AW)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_i         (addr_i),
    .cpu_strobe_n_i (cpu_strobe_n_i),
    .ctl_strobe_n_i (ctl_strobe_n_i),
    .adv_n_i        (adv_n_i),
    .ce_n_i         (ce_n_i),
    .lane_we_n_i    (lane_we_n_i),
    .acc_addr_o     (acc_addr),
    .acc_op_o       (acc_op),
    .wr_lane_o      (wr_lane)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      rd_en_q   <= (acc_op == OP_READ);
      rd_addr_q <= acc_addr;
      valid_q   <= rd_en_q;
    end
  end

  bsram_array #(.AW(AW), .DEPTH(DEPTH)) array_i (
    .clk       (clk),
    .wr_lane_i (wr_lane),
    .wr_addr_i (acc_addr),
    .wdata_i   (wdata_i),
    .rd_en_i   (rd_en_q),
    .rd_addr_i (rd_addr_q),
    .rdata_o   (rdata_o)
  );

  assign rvalid_o = valid_q && !oe_n_i;

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_op == OP_READ) |-> ##2 valid_q);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> !oe_n_i);

  // R3
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane != '0) |-> ##2 !valid_q);
endmodule

// File: tb/bsram_core_tb_top.sv
`timescale 1ns/1ps
module bsram_core_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int NVEC  = 21;

  typedef struct packed {
    logic        cpu_n;
    logic        ctl_n;
    logic        adv_n;
    logic        ce_n;
    logic [1:0]  we_n;
    logic [5:0]  addr;
    logic [17:0] wd;
    logic        chk;
    logic        ev;
    logic [17:0] ed;
    logic [3:0]  req;
  } vec_t;

  // Each row: stimulus and the expected result of that row's own access.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,1'b1,1'b0,2'b00,6'h10,18'h12345,1'b1,1'b0,18'h0,4'd3}, // R3 load+write
    '{1'b1,1'b1,1'b0,1'b0,2'b00,6'h00,18'h0A0A1,1'b1,1'b0,18'h0,4'd6}, // R6 0x11
    '{1'b1,1'b1,1'b0,1'b0,2'b00,6'h00,18'h0B0B2,1'b1,1'b0,18'h0,4'd6}, // R6 0x12
    '{1'b1,1'b1,1'b0,1'b0,2'b00,6'h00,18'h0C0C3,1'b1,1'b0,18'h0,4'd6}, // R6 0x13
    '{1'b0,1'b0,1'b1,1'b0,2'b00,6'h12,18'h3FFFF,1'b1,1'b1,18'h0B0B2,4'd2}, // R2 forced read
    '{1'b1,1'b1,1'b0,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h0C0C3,4'd6}, // R6 base^1
    '{1'b1,1'b1,1'b1,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h0C0C3,4'd5}, // R5 wait
    '{1'b1,1'b1,1'b0,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h12345,4'd6}, // R6 base^2
    '{1'b1,1'b1,1'b0,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h0A0A1,4'd6}, // R6 base^3
    '{1'b1,1'b1,1'b0,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h0B0B2,4'd7}, // R7 wrap
    '{1'b0,1'b1,1'b1,1'b0,2'b11,6'h21,18'h0,1'b0,1'b0,18'h0,4'd8},     // R8 cycle 1
    '{1'b1,1'b1,1'b1,1'b0,2'b00,6'h00,18'h2AB54,1'b1,1'b0,18'h0,4'd8}, // R8 cycle 2
    '{1'b1,1'b1,1'b1,1'b0,2'b10,6'h00,18'h00000,1'b1,1'b0,18'h0,4'd9}, // R9 low lane
    '{1'b1,1'b1,1'b1,1'b0,2'b01,6'h00,18'h3FFFF,1'b1,1'b0,18'h0,4'd9}, // R9 high lane
    '{1'b1,1'b1,1'b1,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h3FE00,4'd9}, // R9 readback
    '{1'b1,1'b0,1'b1,1'b1,2'b00,6'h13,18'h11111,1'b1,1'b0,18'h0,4'd4}, // R4 disabled write
    '{1'b1,1'b1,1'b1,1'b0,2'b11,6'h00,18'h0,1'b1,1'b0,18'h0,4'd4},     // R4 ce ignored
    '{1'b1,1'b0,1'b1,1'b0,2'b11,6'h13,18'h0,1'b1,1'b1,18'h0C0C3,4'd4}, // R4 no write seen
    '{1'b1,1'b1,1'b0,1'b0,2'b11,6'h00,18'h0,1'b1,1'b1,18'h0B0B2,4'd6}, // R6 from base 3
    '{1'b1,1'b1,1'b1,1'b0,2'b11,6'h00,18'h0,1'b0,1'b0,18'h0,4'd0},
    '{1'b1,1'b1,1'b1,1'b0,2'b11,6'h00,18'h0,1'b0,1'b0,18'h0,4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b0;
  logic [1:0] we_n = 2'b11;
  logic [17:0] wd = '0;
  logic [17:0] rdata;
  logic rvalid;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsram_core #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr),
    .cpu_strobe_n_i(cpu_n), .ctl_strobe_n_i(ctl_n), .adv_n_i(adv_n),
    .ce_n_i(ce_n), .lane_we_n_i(we_n), .wdata_i(wd), .oe_n_i(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cpu_n = v.cpu_n; ctl_n = v.ctl_n; adv_n = v.adv_n; ce_n = v.ce_n;
    we_n = v.we_n; addr = v.addr; wd = v.wd;
  endtask

  task automatic idle();
    cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1; we_n = 2'b11;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {17'd0, rvalid}, 18'd0);
    rst_n = 1'b1;
    idle(); ce_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 no read before load", {17'd0, rvalid}, 18'd0);

    // Table walk: row i checked two negedges after it is driven
    for (int i = 0; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2 && VEC[i-2].chk) begin
        check($sformatf("R%0d row %0d valid", VEC[i-2].req, i-2), {17'd0, rvalid}, {17'd0, VEC[i-2].ev});
        if (VEC[i-2].ev)
          check($sformatf("R%0d row %0d data", VEC[i-2].req, i-2), rdata, VEC[i-2].ed);
      end
      if (i < NVEC) drive(VEC[i]); else idle();
    end

    // R1: second reset clears captured enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {17'd0, rvalid}, 18'd0);
    rst_n = 1'b1; idle(); ce_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {17'd0, rvalid}, 18'd0);

    // R10: latency of a CPU-strobe read
    cpu_n = 1'b0; addr = 6'h10;
    @(negedge clk);
    idle();
    check("R10 not yet valid", {17'd0, rvalid}, 18'd0);
    @(negedge clk);
    check("R10 valid", {17'd0, rvalid}, 18'd1);
    check("R10 data", rdata, 18'h12345);

    // R11: output enable gates valid without a clock
    oe_n = 1'b1; #0.5;
    check("R11 masked valid", {17'd0, rvalid}, 18'd0);
    check("R11 data held", rdata, 18'h12345);
    oe_n = 1'b0; #0.5;
    check("R11 unmasked valid", {17'd0, rvalid}, 18'd1);
    oe_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b0; #0.5;
    check("R11 state untouched", rdata, 18'h12345);
    check("R11 valid after edge", {17'd0, rvalid}, 18'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule